// File: doc/BRIEF.md
# Indirect Operand Fetch Unit

This block carries out the memory side of register-indirect instructions in a 16-bit CPU whose memory is word-addressed. The decode stage hands it a pointer-register selector, the pointer's current value, a read or write request and, for writes, the data word. The unit runs one or two word accesses on a request/acknowledge memory port. It then returns the operand, or signals that the store is complete. In the same cycle it presents the updated pointer value with a write-back strobe for the register file.

How the pointer moves depends on the selector. Selectors 0 to 3 and 7 never change it. Selectors 4 and 5 step it forward after the access. Selector 6 acts as a stack pointer: reads step it back before the access and writes step it forward after. A one-shot byte-pair prefix, raised by the decoder on `dbl_set`, affects only the next accepted request. On a read through an advancing or stack selector it joins the low bytes of two adjacent words. On a read through a fixed selector it copies one word's low byte into both halves of the result.

Top module: `iofu_fetch_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_req` and `done` are low, and the byte-pair flag is clear, so the first read returns a full word.
- R2: A read through selector 0, 1, 2, 3 or 7 without the prefix makes one access at the pointer, returns that word and raises no write-back.
- R3: A read through selector 4 or 5 without the prefix makes one access at the pointer and writes back pointer+1.
- R4: A read through selector 6 without the prefix makes one access at pointer-1 and writes back pointer-1, wrapping modulo 2^16.
- R5: A prefixed read through selector 4 or 5 reads the words at pointer and pointer+1. The result is {low byte of second word in bits 15:8, low byte of first word in bits 7:0}, and pointer+2 is written back.
- R6: A prefixed read through selector 6 reads the words at pointer-2 and pointer-1, joins them as in R5 and writes back pointer-2.
- R7: A prefixed read through selector 0 to 3 or 7 makes one access at the pointer, returns its low byte in both bits 15:8 and 7:0, and raises no write-back.
- R8: The prefix is consumed by the next accepted request, whether read or write. A prefix raised in the same cycle as an accepted request applies to the following request, not to that one.
- R9: A write stores `wr_data` at the pointer in exactly one access, with or without the prefix. Selectors 4, 5 and 6 write back pointer+1; the other selectors raise no write-back.
- R10: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`. `done` is a one-cycle pulse in the cycle after the final acknowledge, together with `rd_data` and the write-back.
- R11: A `start` raised while `busy` is high is ignored: the running operation finishes unchanged and no extra operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted while idle |
| start_write | input | 1 | 1 = store, 0 = load |
| start_sel | input | 3 | Pointer-register selector |
| start_ptr | input | 16 | Current pointer value |
| start_wdata | input | 16 | Word to store |
| dbl_set | input | 1 | One-shot byte-pair prefix |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Load data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |
| done | output | 1 | Operation complete pulse |
| rd_data | output | 16 | Loaded operand |
| ptr_wb_en | output | 1 | Pointer write-back strobe |
| ptr_wb_sel | output | 3 | Register to write back |
| ptr_wb_val | output | 16 | Updated pointer |

## Verification
The prefix strobe and the acceptance of a request can land on the same clock edge. Only then does the ordering rule of R8 come into play. The bench raises `dbl_set` and `start` together on a fixed-selector read. It expects that read to return the plain word, the next fixed-selector read to return the duplicated low byte, and a third read to return a plain word again. A second pairing, a `start` during a busy operation, is provoked with a slow memory, and the bench checks that the scoreboard sees exactly one completion.

// File: rtl/iofu_pkg.sv
package iofu_pkg;

    localparam int SEL_W = 3;

    // selector codes whose pointer behaviour differs
    localparam logic [SEL_W-1:0] SEL_ADV_A = 3'd4;
    localparam logic [SEL_W-1:0] SEL_ADV_B = 3'd5;
    localparam logic [SEL_W-1:0] SEL_STACK = 3'd6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } state_t;

    function automatic logic sel_advances(input logic [SEL_W-1:0] sel);
        return (sel == SEL_ADV_A) || (sel == SEL_ADV_B);
    endfunction

endpackage

// File: rtl/iofu_ptr_rules.sv
module iofu_ptr_rules
    import iofu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              is_write,
    input  logic              dbl,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              wb_en,
    output logic              two_acc,
    output logic              replicate
);

    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

    logic adv;
    logic stk;

    always_comb begin
        adv        = sel_advances(sel);
        stk        = (sel == SEL_STACK);
        first_addr = ptr;
        next_ptr   = ptr;
        wb_en      = 1'b0;
        two_acc    = 1'b0;
        replicate  = 1'b0;
        if (is_write) begin
            // stores never pair up; stack selector behaves as a push
            if (adv || stk) begin
                next_ptr = ptr + STEP1;
                wb_en    = 1'b1;
            end
        end else if (dbl) begin
            if (adv) begin
                two_acc  = 1'b1;
                next_ptr = ptr + STEP2;
                wb_en    = 1'b1;
            end else if (stk) begin
                two_acc    = 1'b1;
                first_addr = ptr - STEP2;
                next_ptr   = ptr - STEP2;
                wb_en      = 1'b1;
            end else begin
                replicate = 1'b1;
            end
        end else begin
            if (adv) begin
                next_ptr = ptr + STEP1;
                wb_en    = 1'b1;
            end else if (stk) begin
                first_addr = ptr - STEP1;
                next_ptr   = ptr - STEP1;
                wb_en      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iofu_byte_merge.sv
module iofu_byte_merge #(
    parameter int DATA_W = 16
) (
    input  logic                  two_acc,
    input  logic                  replicate,
    input  logic [DATA_W/2-1:0]   lo_saved,
    input  logic [DATA_W-1:0]     rdata,
    output logic [DATA_W-1:0]     word
);

    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        if (replicate) begin
            word = {rdata[BYTE_W-1:0], rdata[BYTE_W-1:0]};
        end else if (two_acc) begin
            word = {rdata[BYTE_W-1:0], lo_saved};
        end else begin
            word = rdata;
        end
    end

endmodule

// File: rtl/iofu_fetch_unit.sv
module iofu_fetch_unit
    import iofu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [2:0]        start_sel,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              dbl_set,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ptr_wb_en,
    output logic [2:0]        ptr_wb_sel,
    output logic [ADDR_W-1:0] ptr_wb_val
);

    localparam int BYTE_W = DATA_W / 2;

    typedef struct packed {
        state_t            st;
        logic              dbl;
        logic              wr;
        logic              two;
        logic              second;
        logic              repl;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] lo;
        logic              wb_en;
        logic [ADDR_W-1:0] nptr;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] result;
        logic              done;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic              accept;
    logic [ADDR_W-1:0] rule_addr;
    logic [ADDR_W-1:0] rule_nptr;
    logic              rule_wb;
    logic              rule_two;
    logic              rule_repl;
    logic [DATA_W-1:0] merged;

    iofu_ptr_rules #(.ADDR_W(ADDR_W)) i_rules (
        .is_write   (start_write),
        .dbl        (r_q.dbl),
        .sel        (start_sel),
        .ptr        (start_ptr),
        .first_addr (rule_addr),
        .next_ptr   (rule_nptr),
        .wb_en      (rule_wb),
        .two_acc    (rule_two),
        .replicate  (rule_repl)
    );

    iofu_byte_merge #(.DATA_W(DATA_W)) i_merge (
        .two_acc   (r_q.two),
        .replicate (r_q.repl),
        .lo_saved  (r_q.lo),
        .rdata     (mem_rdata),
        .word      (merged)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        accept   = start && (r_q.st == ST_IDLE);

        // a new prefix wins over consumption in the same cycle
        if (dbl_set) begin
            r_d.dbl = 1'b1;
        end else if (accept) begin
            r_d.dbl = 1'b0;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st     = ST_BUS;
                    r_d.wr     = start_write;
                    r_d.sel    = start_sel;
                    r_d.wdata  = start_wdata;
                    r_d.addr   = rule_addr;
                    r_d.nptr   = rule_nptr;
                    r_d.wb_en  = rule_wb;
                    r_d.two    = rule_two;
                    r_d.repl   = rule_repl;
                    r_d.second = 1'b0;
                end
            end
            ST_BUS: begin
                if (mem_ack) begin
                    if (r_q.two && !r_q.second) begin
                        r_d.second = 1'b1;
                        r_d.lo     = mem_rdata[BYTE_W-1:0];
                        r_d.addr   = r_q.addr + ADDR_W'(1);
                    end else begin
                        r_d.st     = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.result = r_q.wr ? '0 : merged;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign mem_req    = (r_q.st == ST_BUS);
    assign mem_we     = r_q.wr;
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.wdata;
    assign done       = r_q.done;
    assign rd_data    = r_q.result;
    assign ptr_wb_en  = r_q.done && r_q.wb_en;
    assign ptr_wb_sel = r_q.sel;
    assign ptr_wb_val = r_q.nptr;

endmodule

// File: rtl/iofu_checker.sv
module iofu_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              done,
    input logic              ptr_wb_en,
    input logic [2:0]        ptr_wb_sel
);

    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

    a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ack));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> !mem_req && done);

    a_r5_adjacent_words: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    a_r2_wb_selectors: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wb_en |-> done && (ptr_wb_sel >= 3'd4) && (ptr_wb_sel <= 3'd6));

endmodule

bind iofu_fetch_unit iofu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .done       (done),
    .ptr_wb_en  (ptr_wb_en),
    .ptr_wb_sel (ptr_wb_sel)
);

// File: tb/test_iofu_fetch_unit.sv
module test_iofu_fetch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_write = 1'b0;
    logic [2:0]  start_sel = '0;
    logic [15:0] start_ptr = '0;
    logic [15:0] start_wdata = '0;
    logic        dbl_set = 1'b0;
    logic        busy, mem_req, mem_we, done, ptr_wb_en;
    logic [15:0] mem_addr, mem_wdata, rd_data, ptr_wb_val;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [2:0]  ptr_wb_sel;

    always #4 clk = ~clk;  // 125 MHz

    iofu_fetch_unit i_iofu_fetch_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
        .start_sel(start_sel), .start_ptr(start_ptr), .start_wdata(start_wdata),
        .dbl_set(dbl_set), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done(done), .rd_data(rd_data), .ptr_wb_en(ptr_wb_en),
        .ptr_wb_sel(ptr_wb_sel), .ptr_wb_val(ptr_wb_val)
    );

    typedef struct {
        logic        wr;
        logic [15:0] data;
        logic        wb;
        logic [15:0] wbv;
        int          acc;
        logic [15:0] waddr;
        logic [15:0] wdat;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mem [256];
    int          nchk = 0;
    int          nfail = 0;
    int          ndone = 0;
    int          acc_total = 0;
    int          acc_base = 0;
    int          lat = 0;
    int          wcnt = 0;
    logic        tb_dbl = 1'b0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // memory model: acknowledges after lat idle cycles
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (rst_n && mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                acc_total <= acc_total + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // monitor: pops the scoreboard at every completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            ndone++;
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected done", 16'h1, 16'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (!e.wr) chk(rd_data == e.data, e.tag, "rd_data", rd_data, e.data);
                chk(ptr_wb_en == e.wb, e.tag, "ptr_wb_en", 16'(ptr_wb_en), 16'(e.wb));
                if (e.wb) chk(ptr_wb_val == e.wbv, e.tag, "ptr_wb_val", ptr_wb_val, e.wbv);
                chk((acc_total - acc_base) == e.acc, e.tag, "access count",
                    16'(acc_total - acc_base), 16'(e.acc));
                if (e.wr) chk(mem[e.waddr[7:0]] == e.wdat, e.tag, "stored word",
                              mem[e.waddr[7:0]], e.wdat);
            end
            acc_base = acc_total;
        end
    end

    function automatic logic [7:0] lob(input logic [15:0] a);
        return mem[a[7:0]][7:0];
    endfunction

    task automatic set_prefix();
        @(negedge clk) dbl_set = 1'b1;
        @(negedge clk) dbl_set = 1'b0;
        tb_dbl = 1'b1;
    endtask

    task automatic run_op(input logic wr, input logic [2:0] sel, input logic [15:0] ptr,
                          input logic [15:0] wd, input bit pfx_same, input bit poke,
                          input string tag);
        exp_t e;
        bit   adv, stk;
        int   want;
        adv = (sel == 3'd4) || (sel == 3'd5);
        stk = (sel == 3'd6);
        e.wr = wr; e.tag = tag; e.data = '0; e.wb = 1'b0; e.wbv = ptr;
        e.acc = 1; e.waddr = ptr; e.wdat = wd;
        if (wr) begin
            e.wb = adv || stk; e.wbv = ptr + 16'd1;
        end else if (tb_dbl) begin
            if (adv) begin
                e.acc = 2; e.wb = 1'b1; e.wbv = ptr + 16'd2;
                e.data = {lob(ptr + 16'd1), lob(ptr)};
            end else if (stk) begin
                e.acc = 2; e.wb = 1'b1; e.wbv = ptr - 16'd2;
                e.data = {lob(ptr - 16'd1), lob(ptr - 16'd2)};
            end else begin
                e.data = {lob(ptr), lob(ptr)};
            end
        end else begin
            if (adv) begin
                e.wb = 1'b1; e.wbv = ptr + 16'd1; e.data = mem[ptr[7:0]];
            end else if (stk) begin
                e.wb = 1'b1; e.wbv = ptr - 16'd1; e.data = mem[8'(ptr - 16'd1)];
            end else begin
                e.data = mem[ptr[7:0]];
            end
        end
        sb.push_back(e);
        tb_dbl = pfx_same;
        want = ndone + 1;
        @(negedge clk);
        start = 1'b1; start_write = wr; start_sel = sel; start_ptr = ptr;
        start_wdata = wd; dbl_set = pfx_same;
        @(negedge clk);
        start = 1'b0; dbl_set = 1'b0;
        if (poke) begin
            start = 1'b1; start_write = 1'b1; start_sel = 3'd4;
            start_ptr = 16'h00F0; start_wdata = 16'hDEAD;
            @(negedge clk);
            start = 1'b0;
        end
        while (ndone < want) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {~i[7:0], i[7:0] ^ 8'h5A};
        repeat (4) @(negedge clk);
        // R1: idle state after reset
        chk(busy == 1'b0, "R1", "busy", 16'(busy), 16'h0);
        chk(mem_req == 1'b0, "R1", "mem_req", 16'(mem_req), 16'h0);
        chk(done == 1'b0, "R1", "done", 16'(done), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 3'd0, 16'd10, '0, 0, 0, "R1");
        // R2 fixed selectors
        run_op(1'b0, 3'd3, 16'd20, '0, 0, 0, "R2");
        run_op(1'b0, 3'd7, 16'd30, '0, 0, 0, "R2");
        // R3 advancing selectors, including carry past 0xFF
        run_op(1'b0, 3'd4, 16'd40, '0, 0, 0, "R3");
        run_op(1'b0, 3'd5, 16'h00FF, '0, 0, 0, "R3");
        // R4 stack read, including wrap below zero
        run_op(1'b0, 3'd6, 16'd50, '0, 0, 0, "R4");
        run_op(1'b0, 3'd6, 16'd0, '0, 0, 0, "R4");
        // R5 byte pairs through advancing selectors
        set_prefix(); run_op(1'b0, 3'd4, 16'd60, '0, 0, 0, "R5");
        set_prefix(); run_op(1'b0, 3'd5, 16'd70, '0, 0, 0, "R5");
        // R6 byte pair through stack
        set_prefix(); run_op(1'b0, 3'd6, 16'd80, '0, 0, 0, "R6");
        // R7 replication through fixed selectors
        set_prefix(); run_op(1'b0, 3'd2, 16'd90, '0, 0, 0, "R7");
        set_prefix(); run_op(1'b0, 3'd7, 16'd91, '0, 0, 0, "R7");
        // R8 one-shot, then prefix in the same cycle as a request
        run_op(1'b0, 3'd2, 16'd90, '0, 0, 0, "R8");
        run_op(1'b0, 3'd0, 16'd100, '0, 1, 0, "R8");
        run_op(1'b0, 3'd0, 16'd100, '0, 0, 0, "R8");
        run_op(1'b0, 3'd0, 16'd100, '0, 0, 0, "R8");
        // R9 stores
        run_op(1'b1, 3'd4, 16'd120, 16'hA1B2, 0, 0, "R9");
        run_op(1'b1, 3'd6, 16'd130, 16'hC3D4, 0, 0, "R9");
        run_op(1'b1, 3'd1, 16'd140, 16'hE5F6, 0, 0, "R9");
        set_prefix(); run_op(1'b1, 3'd5, 16'd150, 16'h1357, 0, 0, "R9");
        run_op(1'b0, 3'd0, 16'd150, '0, 0, 0, "R9");
        // R10 handshake under varied memory latency
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int s = 0; s < 8; s++) begin
                if (s[0]) set_prefix();
                run_op(1'b0, 3'(s), 16'(8'd160 + 8'(s * 5)), '0, 0, 0, "R10");
            end
        end
        // R11 start while busy is ignored
        lat = 3;
        run_op(1'b0, 3'd4, 16'd200, '0, 0, 1, "R11");
        set_prefix(); run_op(1'b0, 3'd6, 16'd210, '0, 0, 1, "R11");
        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R11", "pending items", 16'(sb.size()), 16'h0);
        chk(mem[8'hF0] != 16'hDEAD, "R11", "ignored store", mem[8'hF0], 16'hDEAD ^ 16'hFFFF);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule